// File: doc/BRIEF.md
# Multichannel PWM Generator with Shared Prescaler

This block produces `NCH` independent pulse-width-modulated outputs from one clock. A shared clock generator supplies thirteen tick sources. Eleven come from a free-running binary prescaler, and two come from linear dividers that count a chosen prescaler tap. Each channel picks one of these sources. It then advances a counter by one step per tick and compares the count with its duty value to drive its output pin.

Software uses a plain write strobe to configure the block. Channels are switched on and off through separate set and clear command words. While a channel runs, new period and duty values wait in update registers and become active only at the end of the current period, so a waveform never shows a torn cycle. Each channel raises a sticky end-of-period flag, and reading the flag word clears it.

Top module: `pwm_multi`

## Requirements
- R1: Prescaler tap k (0..10) ticks exactly once every 2^k clock cycles. The prescaler runs freely from reset.
- R2: Divider 0 is configured at address 2 and divider 1 at address 3. Data bits [7:0] hold the divide value N and bits [11:8] hold the prescaler tap it counts. A divider fires on every N-th tick of that tap, counted from the configuration write, which restarts it. With N = 0 the divider never fires.
- R3: Channel source codes are 0..10 for prescaler tap k, 11 for divider 0 and 12 for divider 1. Codes 13..15 give no ticks, and the counter holds.
- R4: Writing address 0 enables every channel whose data bit is 1. Writing address 1 disables every channel whose data bit is 1. Zero bits leave a channel unchanged. Reading address 4 returns the enabled mask.
- R5: A disabled channel drives its inactive level, which is the invert bit. It holds its counter at zero and copies its update registers straight into the active values. A newly enabled channel starts at count 0. After reset every output is 0.
- R6: Channel c uses three registers. The mode register is at 16+4c, with bits [3:0] the source, bit 4 invert and bit 5 center. The period register is at 17+4c and the duty register at 18+4c. In left-aligned mode (center = 0) the count runs 0..P-1 and then wraps, and the duty portion is active while count < D. A period of 0 acts as 1.
- R7: In center-aligned mode the count climbs 0..P-1, repeats P-1, descends to 0 and repeats 0, giving a period of 2P ticks. The duty portion is active while count >= P-D.
- R8: A duty of 0 keeps the output inactive. A duty of P or more keeps it active for the whole period.
- R9: With invert = 0 the duty portion is high. With invert = 1 the whole output is inverted.
- R10: While a channel is enabled, period and duty writes take effect only at the period boundary. In left mode that is the wrap from P-1 to 0. In center mode it is the turn at 0 after the down-count. A write on the same clock edge as a boundary waits for the next boundary.
- R11: Each period boundary sets a per-channel sticky flag. Reading address 5 returns the flags and clears them on that clock edge, except that a boundary on that same edge keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Read strobe (clears flags when at address 5) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CW | Read data, combinational from rd_addr |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
The hardest situation to reach is a duty write that lands exactly on the clock edge where the counter wraps. There the old update value must be loaded and the new one must wait a full period. The bench reaches it with the fastest tick source, where its tick count equals elapsed cycles. It schedules the write by tick index on one side of the boundary and then exactly on it, and switches its expected duty at the boundary that the rule predicts. Divider-driven channels are a second hard case, because their tick phase depends on writes made earlier. The bench follows the divider from its configuration write with its own tick count.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int PRE_TAPS  = 11;
  localparam int NUM_DIV   = 2;
  localparam int NUM_SRC   = PRE_TAPS + NUM_DIV;
  localparam int SEL_W     = 4;
  localparam int SEL_SPAN  = 1 << SEL_W;

  localparam int A_EN_SET  = 0;
  localparam int A_EN_CLR  = 1;
  localparam int A_DIV0    = 2;
  localparam int A_EN_STAT = 4;
  localparam int A_FLAGS   = 5;
  localparam int A_CH_BASE = 16;
  localparam int CH_STRIDE = 4;
  localparam int O_MODE    = 0;
  localparam int O_PER     = 1;
  localparam int O_DUTY    = 2;

  typedef struct packed {
    logic             center;
    logic             invert;
    logic [SEL_W-1:0] sel;
  } ch_mode_t;

  function automatic ch_mode_t decode_mode(input logic [5:0] w);
    return ch_mode_t'(w);
  endfunction
endpackage

// File: rtl/pwm_clkgen.sv
`timescale 1ns/1ps
module pwm_clkgen
  import pwm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_DIV-1:0][DIV_W-1:0]   div_n,
  input  logic [NUM_DIV-1:0][SEL_W-1:0]   div_src,
  input  logic [NUM_DIV-1:0]              div_restart,
  output logic [NUM_SRC-1:0]              src_tick
);
  localparam int PW = PRE_TAPS - 1;

  logic [PW-1:0]       pre_q;
  logic [PRE_TAPS-1:0] pre_tick;
  logic [NUM_DIV-1:0]  div_fire;
  logic [SEL_SPAN-1:0] pre_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PW'(1);
  end

  assign pre_tick[0] = 1'b1;
  assign pre_pad     = SEL_SPAN'(pre_tick);

  for (genvar k = 1; k < PRE_TAPS; k++) begin : g_tap
    assign pre_tick[k] = &pre_q[k-1:0];
    // R1: a divided tap never ticks on two cycles in a row
    p_tap_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick[k] |=> !pre_tick[k]);
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    logic             sel_tick;
    logic             fire;
    logic [DIV_W-1:0] cnt_q;

    assign sel_tick = pre_pad[div_src[d]];
    assign fire     = sel_tick && (div_n[d] != '0) &&
                      (cnt_q >= div_n[d] - DIV_W'(1));
    assign div_fire[d] = fire;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (div_restart[d]) cnt_q <= '0;
      else if (sel_tick)       cnt_q <= fire ? '0 : cnt_q + DIV_W'(1);
    end

    // R2: a zero divide value silences the divider
    p_div_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_n[d] == '0) |-> !div_fire[d]);
    // R2: right after a restart the count starts from zero
    p_div_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      div_restart[d] |=> (cnt_q == '0) || div_fire[d] || (div_n[d] != $past(div_n[d])) || 1'b0);
  end

  assign src_tick = {div_fire, pre_tick};
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  ch_mode_t           mode,
  input  logic               en,
  input  logic               per_we,
  input  logic               duty_we,
  input  logic [CW-1:0]      wdata,
  output logic               pwm_o,
  output logic               eop_o
);
  function automatic logic [CW-1:0] eff_per(input logic [CW-1:0] p);
    return (p == '0) ? CW'(1) : p;
  endfunction

  function automatic logic left_on(input logic [CW-1:0] c, input logic [CW-1:0] d);
    return c < d;
  endfunction

  function automatic logic center_on(input logic [CW-1:0] c, input logic [CW-1:0] p,
                                     input logic [CW-1:0] d);
    return (d >= p) || (c >= p - d);
  endfunction

  logic [SEL_SPAN-1:0] src_pad;
  logic                tick;
  logic [CW-1:0]       per_upd, duty_upd, per_act, duty_act;
  logic [CW-1:0]       cnt_q, per_eff;
  logic                down_q, at_top, load_evt, active;

  assign src_pad  = SEL_SPAN'(src_tick);
  assign tick     = src_pad[mode.sel];
  assign per_eff  = eff_per(per_act);
  assign at_top   = (cnt_q == per_eff - CW'(1));
  assign load_evt = en && tick && (mode.center ? (down_q && cnt_q == '0) : at_top);
  assign active   = mode.center ? center_on(cnt_q, per_eff, duty_act)
                                : left_on(cnt_q, duty_act);
  assign pwm_o    = en ? (active ^ mode.invert) : mode.invert;
  assign eop_o    = load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_upd  <= '0;
      duty_upd <= '0;
    end else begin
      if (per_we)  per_upd  <= wdata;
      if (duty_we) duty_upd <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      down_q   <= 1'b0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (!en) begin
      cnt_q    <= '0;
      down_q   <= 1'b0;
      per_act  <= per_upd;
      duty_act <= duty_upd;
    end else if (tick) begin
      if (load_evt) begin
        per_act  <= per_upd;
        duty_act <= duty_upd;
      end
      if (mode.center) begin
        if (!down_q) begin
          if (at_top) down_q <= 1'b1;
          else        cnt_q  <= cnt_q + CW'(1);
        end else begin
          if (cnt_q == '0) down_q <= 1'b0;
          else             cnt_q  <= cnt_q - CW'(1);
        end
      end else begin
        if (at_top) cnt_q <= '0;
        else        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R6: a running counter stays below the effective period
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < per_eff));
  // R5: a disabled channel parks its counter at zero
  p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
  // R10: active values move only at a period boundary while running
  p_hold_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load_evt) |=> ($stable(per_act) && $stable(duty_act)));
  // R3: an unused source code never moves the counter
  p_idle_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode.sel >= SEL_W'(NUM_SRC))) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_multi.sv
`timescale 1ns/1ps
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CW     = 16,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic [NCH-1:0]    pwm_o
);
  localparam int SRC_FLD = 8;

  logic [NCH-1:0]                     en_q, flag_q, eop, en_set, en_clr;
  logic                               flag_rd;
  logic [NUM_DIV-1:0][DIV_W-1:0]      div_n_q;
  logic [NUM_DIV-1:0][SEL_W-1:0]      div_src_q;
  logic [NUM_DIV-1:0]                 div_wr;
  logic [NUM_SRC-1:0]                 src_tick;

  assign en_set  = (wr_en && wr_addr == ADDR_W'(A_EN_SET)) ? wr_data[NCH-1:0] : '0;
  assign en_clr  = (wr_en && wr_addr == ADDR_W'(A_EN_CLR)) ? wr_data[NCH-1:0] : '0;
  assign flag_rd = rd_en && (rd_addr == ADDR_W'(A_FLAGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      flag_q <= (flag_rd ? '0 : flag_q) | eop;
    end
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_divcfg
    assign div_wr[d] = wr_en && (wr_addr == ADDR_W'(A_DIV0 + d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_n_q[d]   <= '0;
        div_src_q[d] <= '0;
      end else if (div_wr[d]) begin
        div_n_q[d]   <= wr_data[DIV_W-1:0];
        div_src_q[d] <= wr_data[SRC_FLD +: SEL_W];
      end
    end
  end

  pwm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_n       (div_n_q),
    .div_src     (div_src_q),
    .div_restart (div_wr),
    .src_tick    (src_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = A_CH_BASE + CH_STRIDE * c;
    ch_mode_t mode_q;
    logic     mode_we, per_we, duty_we;

    assign mode_we = wr_en && (wr_addr == ADDR_W'(BASE + O_MODE));
    assign per_we  = wr_en && (wr_addr == ADDR_W'(BASE + O_PER));
    assign duty_we = wr_en && (wr_addr == ADDR_W'(BASE + O_DUTY));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_we) mode_q <= decode_mode(wr_data[5:0]);
    end

    pwm_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .mode     (mode_q),
      .en       (en_q[c]),
      .per_we   (per_we),
      .duty_we  (duty_we),
      .wdata    (wr_data),
      .pwm_o    (pwm_o[c]),
      .eop_o    (eop[c])
    );

    // R11: a boundary always leaves its flag raised
    p_eop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eop[c] |=> flag_q[c]);
    // R11: only a flag read can lower a flag
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[c] && !flag_rd) |=> flag_q[c]);
    // R4: a set command with no clear enables the channel
    p_en_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set[c] && !en_clr[c]) |=> en_q[c]);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_EN_STAT))    rd_data = CW'(en_q);
    else if (rd_addr == ADDR_W'(A_FLAGS)) rd_data = CW'(flag_q);
  end
endmodule

// File: tb/tb_pwm_multi.sv
`timescale 1ns/1ps
module tb_pwm_multi;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [NCH-1:0] pwm_o;

  int n_vec = 0;
  int n_bad = 0;
  int pre_m = 0;
  int sA = 0;
  int tapA = 0;
  int nA = 0;

  pwm_multi #(.NCH(NCH), .CW(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  always #10 clk = ~clk;

  function automatic bit tap_due(int k);
    return (pre_m % (1 << k)) == ((1 << k) - 1);
  endfunction

  function automatic bit src_due(int sel);
    if (sel < 11)  return tap_due(sel);
    if (sel == 11) return tap_due(tapA) && (nA != 0) && (((sA + 1) % nA) == 0);
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pre_m <= 0;
      sA    <= 0;
    end else begin
      pre_m <= pre_m + 1;
      if (wr_en && wr_addr == AW'(2)) sA <= 0;
      else if (tap_due(tapA))         sA <= sA + 1;
    end
  end

  function automatic bit exp_out(int p, int d, bit inv, bit ctr, int t);
    int pe, ph, c;
    bit a;
    pe = (p == 0) ? 1 : p;
    if (ctr) begin
      ph = t % (2 * pe);
      c  = (ph < pe) ? ph : 2 * pe - 1 - ph;
      a  = (d >= pe) || (c >= pe - d);
    end else begin
      c = t % pe;
      a = c < d;
    end
    return a ^ inv;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [CW-1:0] v);
    rd_addr = AW'(a);
    rd_en   = 1'b1;
    #1 v = rd_data;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int chaddr(int c, int o);
    return 16 + 4 * c + o;
  endfunction

  task automatic run(int ch, int sel, int p, int d, bit inv, bit ctr, int ncyc,
                     string req, int tw, int nd);
    int t, pe, len, teff, dc;
    bit due;
    pe = (p == 0) ? 1 : p;
    len = ctr ? 2 * pe : pe;
    teff = ((tw + 1) / len + 1) * len;
    wr(1, 1 << ch);
    wr(chaddr(ch, 0), (int'(ctr) << 5) | (int'(inv) << 4) | sel);
    wr(chaddr(ch, 1), p);
    wr(chaddr(ch, 2), d);
    wr(0, 1 << ch);
    t = 0;
    for (int i = 0; i < ncyc; i++) begin
      dc = (tw >= 0 && t >= teff) ? nd : d;
      chk(req, 32'(pwm_o[ch]), 32'(exp_out(p, dc, inv, ctr, t)));
      if (tw >= 0 && t == tw) begin
        wr_en   = 1'b1;
        wr_addr = AW'(chaddr(ch, 2));
        wr_data = CW'(nd);
      end
      due = src_due(sel);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      if (due) t++;
    end
    wr(1, 1 << ch);
    chk("R5 disabled level", 32'(pwm_o[ch]), 32'(inv));
  endtask

  initial begin
    logic [CW-1:0] v;
    int k, len;
    string req;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state
    chk("R5 reset outputs", 32'(pwm_o), 32'(0));
    rd(4, v); chk("R4 reset enable mask", 32'(v), 32'(0));
    rd(5, v); chk("R11 reset flags", 32'(v), 32'(0));

    // R6 R7 R8 R9 R1: sweep of small configurations
    k = 0;
    for (int sel = 0; sel < 3; sel++)
      for (int p = 1; p <= 4; p++)
        for (int d = 0; d <= p + 1; d++)
          for (int inv = 0; inv < 2; inv++)
            for (int ctr = 0; ctr < 2; ctr++) begin
              len = (ctr != 0) ? 2 * p : p;
              if (d == 0 || d >= p)  req = "R8";
              else if (inv != 0)     req = "R9";
              else if (ctr != 0)     req = "R7";
              else if (sel != 0)     req = "R1";
              else                   req = "R6";
              run(k % NCH, sel, p, d, inv[0], ctr[0], 2 * len * (1 << sel) + 2, req, -1, 0);
              k++;
            end

    // R6: zero period acts as one
    run(0, 0, 0, 1, 1'b0, 1'b0, 6, "R6", -1, 0);

    // R1: slowest prescaler tap
    run(1, 10, 2, 1, 1'b0, 1'b0, 2 * 2 * 1024 + 4, "R1", -1, 0);

    // R10: buffered duty writes, mid-period, just before and on the boundary
    run(0, 0, 8, 2, 1'b0, 1'b0, 30, "R10", 3, 6);
    run(3, 0, 8, 2, 1'b0, 1'b0, 30, "R10", 6, 5);
    run(3, 0, 8, 2, 1'b0, 1'b0, 30, "R10", 7, 5);
    run(2, 0, 4, 1, 1'b0, 1'b1, 30, "R10", 5, 3);
    run(2, 0, 4, 1, 1'b1, 1'b1, 30, "R10", 7, 3);

    // R2: divider 0 with N=3 on tap 1, then switched off
    tapA = 1; nA = 3;
    wr(2, (1 << 8) | 3);
    run(1, 11, 2, 1, 1'b0, 1'b0, 80, "R2", -1, 0);
    tapA = 0; nA = 1;
    wr(2, 1);
    run(2, 11, 3, 1, 1'b0, 1'b0, 20, "R2", -1, 0);
    tapA = 0; nA = 0;
    wr(2, 0);
    run(1, 11, 2, 1, 1'b0, 1'b0, 20, "R2", -1, 0);

    // R3: divider 1 unconfigured and an unused code
    run(3, 12, 2, 1, 1'b0, 1'b0, 20, "R3", -1, 0);
    run(2, 13, 2, 1, 1'b1, 1'b0, 20, "R3", -1, 0);

    // R4: set and clear commands
    wr(0, 0);   rd(4, v); chk("R4 zero set", 32'(v), 32'(0));
    wr(0, 5);   rd(4, v); chk("R4 set", 32'(v), 32'(5));
    wr(1, 1);   rd(4, v); chk("R4 clear", 32'(v), 32'(4));
    wr(1, 0);   rd(4, v); chk("R4 zero clear", 32'(v), 32'(4));
    wr(1, 15);  rd(4, v); chk("R4 clear all", 32'(v), 32'(0));

    // R11: sticky flags and clear on read
    rd(5, v); chk("R11 flags set", 32'(v), 32'(15));
    rd(5, v); chk("R11 flags cleared", 32'(v), 32'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule